// File: doc/BRIEF.md
# Interrupt Status and Enable Unit

This block gathers four level event lines from a FIFO-based peripheral into a single interrupt request. Each event line is watched for a low-to-high transition. A transition sets a sticky status bit, whatever that source's enable bit holds. A per-source enable register and one global enable bit decide whether the latched bits reach the interrupt output.

Software reaches the block through a plain 32-bit register port with fixed byte offsets. There are three registers:

| Offset | Contents |
|---|---|
| 0x1C | Global enable, bit 31 |
| 0x20 | Status |
| 0x28 | Enables |

The status and enable registers share one bit layout:

| Bit | Source |
|---|---|
| 3 | Read FIFO full |
| 2 | Write FIFO empty |
| 1 | Read FIFO half full |
| 0 | Write FIFO half full |

Writing a 1 to a status bit inverts that bit, so software uses the same write both to acknowledge a source and to force one. Writes take effect at the clock edge that samples them. Reads are combinational from the addressed register.

Top module: `irq_agg_unit`

## Requirements
- R1: A synchronous reset clears the status bits, the enable bits and the global enable. While reset is held and after it is released, the interrupt output is low and all three registers read 0.
- R2: A rising edge on ev_i[k] sets status bit k at the next clock edge. A source held high sets its bit only once. Once software clears that bit, it stays 0 while the line remains high. A line that is already high in the first cycle after reset counts as a rising edge.
- R3: A write to offset 0x20 inverts every status bit whose data bit is 1. Status bits whose data bit is 0 keep their value.
- R4: When a rising edge and a toggling write hit the same status bit in the same cycle, the bit ends up 1.
- R5: A write to offset 0x28 loads data bits 3..0 into the enable register. A 1 enables a source and a 0 disables it.
- R6: A write to offset 0x1C loads data bit 31 into the global enable. Data bits 30..0 of that write have no effect.
- R7: A status bit is captured even when its enable bit or the global enable is 0.
- R8: irq_o is high exactly when the global enable is 1 and at least one status bit is 1 together with its enable bit. It follows register changes in the cycle after the write or edge.
- R9: A read of 0x1C returns the global enable in bit 31, with all other bits 0. Reads of 0x20 and 0x28 return the register in bits 3..0, with bits 31..4 zero. Any other offset reads 0, and writes to any other offset change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ev_i | input | 4 | Level event lines, bit order as in the status layout |
| reg_addr | input | 8 | Byte offset of the register access |
| reg_wr | input | 1 | Write strobe, one access per high cycle |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the addressed register |
| irq_o | output | 1 | Interrupt request |

## Verification
A hardware rising edge and a software toggling write can land on the same status bit in the same clock cycle. The bench provokes this by first latching the bit to 1 and then dropping the event line. In a single cycle it then raises the line again and writes a toggle mask that has that bit set. If the toggle took priority, the bit would end up 0. The check therefore demands that the bit reads back as 1, and that a later toggle alone clears it.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  // Byte offsets of the three registers
  localparam logic [7:0] OFS_GLOBAL = 8'h1C;
  localparam logic [7:0] OFS_STATUS = 8'h20;
  localparam logic [7:0] OFS_ENABLE = 8'h28;

  typedef enum logic [1:0] {
    SEL_NONE   = 2'd0,
    SEL_GLOBAL = 2'd1,
    SEL_STATUS = 2'd2,
    SEL_ENABLE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/irq_rise_det.sv
module irq_rise_det #(
  parameter int NSRC = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] lvl_i,
  output logic [NSRC-1:0] rise_o
);
  logic [NSRC-1:0] prev_q;

  for (genvar k = 0; k < NSRC; k++) begin : g_src
    always_ff @(posedge clk) begin
      if (rst) prev_q[k] <= 1'b0;
      else     prev_q[k] <= lvl_i[k];
    end
    assign rise_o[k] = lvl_i[k] & ~prev_q[k];
  end
endmodule

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
  import irq_agg_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic [AW-1:0] addr_i,
  output reg_sel_e      sel_o
);
  function automatic reg_sel_e decode_sel(input logic [AW-1:0] a);
    if (a == AW'(OFS_GLOBAL))      return SEL_GLOBAL;
    else if (a == AW'(OFS_STATUS)) return SEL_STATUS;
    else if (a == AW'(OFS_ENABLE)) return SEL_ENABLE;
    else                           return SEL_NONE;
  endfunction

  assign sel_o = decode_sel(addr_i);
endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
  parameter int NSRC = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] set_i,
  input  logic [NSRC-1:0] toggle_i,
  output logic [NSRC-1:0] status_o
);
  // Hardware set takes priority over a software toggle on the same bit
  function automatic logic [NSRC-1:0] next_status(
    input logic [NSRC-1:0] cur,
    input logic [NSRC-1:0] set,
    input logic [NSRC-1:0] tog
  );
    return set | (cur ^ tog);
  endfunction

  logic [NSRC-1:0] status_q;

  always_ff @(posedge clk) begin
    if (rst) status_q <= '0;
    else     status_q <= next_status(status_q, set_i, toggle_i);
  end

  assign status_o = status_q;
endmodule

// File: rtl/irq_agg_unit.sv
module irq_agg_unit
  import irq_agg_pkg::*;
#(
  parameter int NSRC    = 4,
  parameter int DW      = 32,
  parameter int AW      = 8,
  parameter int GLB_BIT = 31
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] ev_i,
  input  logic [AW-1:0]   reg_addr,
  input  logic            reg_wr,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   reg_rdata,
  output logic            irq_o
);
  localparam int PADW = DW - NSRC;

  function automatic logic irq_level(
    input logic            glb,
    input logic [NSRC-1:0] st,
    input logic [NSRC-1:0] en
  );
    return glb & (|(st & en));
  endfunction

  // Named internal events, visible to the bound checker
  reg_sel_e        rd_sel;
  logic [NSRC-1:0] ev_rise;
  logic [NSRC-1:0] sw_toggle;
  logic            wr_enable;
  logic            wr_global;
  logic [NSRC-1:0] status_q;
  logic [NSRC-1:0] enable_q;
  logic            gie_q;
  logic            unused_wbits;

  irq_reg_decode #(.AW(AW)) u_dec (
    .addr_i (reg_addr),
    .sel_o  (rd_sel)
  );

  irq_rise_det #(.NSRC(NSRC)) u_rise (
    .clk    (clk),
    .rst    (rst),
    .lvl_i  (ev_i),
    .rise_o (ev_rise)
  );

  assign sw_toggle = (reg_wr && rd_sel == SEL_STATUS) ? reg_wdata[NSRC-1:0] : '0;
  assign wr_enable = reg_wr && (rd_sel == SEL_ENABLE);
  assign wr_global = reg_wr && (rd_sel == SEL_GLOBAL);
  assign unused_wbits = ^reg_wdata;

  irq_status_bank #(.NSRC(NSRC)) u_stat (
    .clk      (clk),
    .rst      (rst),
    .set_i    (ev_rise),
    .toggle_i (sw_toggle),
    .status_o (status_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      enable_q <= '0;
      gie_q    <= 1'b0;
    end else begin
      if (wr_enable) enable_q <= reg_wdata[NSRC-1:0];
      if (wr_global) gie_q    <= reg_wdata[GLB_BIT];
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (rd_sel)
      SEL_GLOBAL: reg_rdata[GLB_BIT] = gie_q;
      SEL_STATUS: reg_rdata = {{PADW{1'b0}}, status_q};
      SEL_ENABLE: reg_rdata = {{PADW{1'b0}}, enable_q};
      default:    reg_rdata = '0;
    endcase
  end

  assign irq_o = irq_level(gie_q, status_q, enable_q);
endmodule

// File: rtl/irq_agg_chk.sv
module irq_agg_chk
  import irq_agg_pkg::*;
#(
  parameter int NSRC = 4,
  parameter int DW   = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            reg_wr,
  input reg_sel_e        rd_sel,
  input logic [DW-1:0]   reg_rdata,
  input logic            irq_o,
  input logic [NSRC-1:0] ev_rise,
  input logic [NSRC-1:0] sw_toggle,
  input logic [NSRC-1:0] status_q,
  input logic [NSRC-1:0] enable_q,
  input logic            gie_q
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (status_q == '0 && enable_q == '0 && !gie_q && !irq_o));

  // R2
  hw_set_chk: assert property (@(posedge clk) disable iff (rst)
    (ev_rise != '0) |=> ((status_q & $past(ev_rise)) == $past(ev_rise)));

  // R3
  status_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ev_rise == '0 && sw_toggle == '0) |=> $stable(status_q));

  // R5
  enable_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(reg_wr && rd_sel == SEL_ENABLE) |=> $stable(enable_q));

  // R8
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !gie_q |-> !irq_o);

  // R8
  irq_source_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> ((status_q & enable_q) != '0));

  // R9
  upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_sel == SEL_STATUS || rd_sel == SEL_ENABLE) |-> (reg_rdata[DW-1:NSRC] == '0));
endmodule

bind irq_agg_unit irq_agg_chk #(.NSRC(NSRC), .DW(DW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .reg_wr    (reg_wr),
  .rd_sel    (rd_sel),
  .reg_rdata (reg_rdata),
  .irq_o     (irq_o),
  .ev_rise   (ev_rise),
  .sw_toggle (sw_toggle),
  .status_q  (status_q),
  .enable_q  (enable_q),
  .gie_q     (gie_q)
);

// File: tb/irq_agg_unit_test.sv
module irq_agg_unit_test;
  localparam logic [7:0] A_GLB = 8'h1C;
  localparam logic [7:0] A_ST  = 8'h20;
  localparam logic [7:0] A_EN  = 8'h28;
  localparam logic [7:0] A_GAP = 8'h24;

  logic        clk = 1'b0;
  logic        rst;
  logic [3:0]  ev;
  logic [7:0]  addr;
  logic        wr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irq_agg_unit uut (
    .clk(clk), .rst(rst), .ev_i(ev), .reg_addr(addr), .reg_wr(wr),
    .reg_wdata(wdata), .reg_rdata(rdata), .irq_o(irq)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  // One clock with the given stimulus; returns at the following negedge
  task automatic step(input logic w, input logic [7:0] a, input logic [31:0] d, input logic [3:0] e);
    ev = e; wr = w; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    addr = a;
    #1;
    v = rdata;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(A_GLB, v); check("R1 global", v, 32'h0);
    rd(A_ST, v);  check("R1 status", v, 32'h0);
    rd(A_EN, v);  check("R1 enable", v, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_capture();
    logic [31:0] v;
    step(1'b0, A_ST, 32'h0, 4'b0101);
    step(1'b0, A_ST, 32'h0, 4'b0000);
    rd(A_ST, v); check("R2 R7 capture while disabled", v, 32'h5);
    check("R8 irq stays low", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_toggle();
    logic [31:0] v;
    step(1'b1, A_ST, 32'hFFFF_FFF3, 4'b0000);
    rd(A_ST, v); check("R3 toggle ones", v, 32'h6);
    step(1'b1, A_ST, 32'h0, 4'b0000);
    rd(A_ST, v); check("R3 zeros keep", v, 32'h6);
  endtask

  task automatic t_enable();
    logic [31:0] v;
    step(1'b1, A_EN, 32'hFFFF_FFFF, 4'b0000);
    rd(A_EN, v); check("R5 R9 enable all", v, 32'hF);
    step(1'b1, A_EN, 32'h0000_0004, 4'b0000);
    rd(A_EN, v); check("R5 enable one", v, 32'h4);
  endtask

  task automatic t_global();
    logic [31:0] v;
    step(1'b1, A_GLB, 32'h7FFF_FFFF, 4'b0000);
    rd(A_GLB, v); check("R6 low bits ignored", v, 32'h0);
    check("R8 irq with global off", {31'b0, irq}, 32'h0);
    step(1'b1, A_GLB, 32'h8000_0000, 4'b0000);
    rd(A_GLB, v); check("R6 R9 global on", v, 32'h8000_0000);
    check("R8 irq raised", {31'b0, irq}, 32'h1);
    step(1'b1, A_EN, 32'h8, 4'b0000);
    check("R8 irq masked", {31'b0, irq}, 32'h0);
    step(1'b1, A_EN, 32'h4, 4'b0000);
    step(1'b1, A_ST, 32'h4, 4'b0000);
    check("R3 R8 irq dropped by toggle", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_race();
    logic [31:0] v;
    step(1'b1, A_ST, 32'h2, 4'b0000);
    rd(A_ST, v); check("R3 cleared", v, 32'h0);
    step(1'b0, A_ST, 32'h0, 4'b1000);
    step(1'b0, A_ST, 32'h0, 4'b0000);
    rd(A_ST, v); check("R2 bit3 set", v, 32'h8);
    step(1'b1, A_ST, 32'h8, 4'b1000);
    rd(A_ST, v); check("R4 set beats toggle", v, 32'h8);
    step(1'b1, A_ST, 32'h8, 4'b0000);
    rd(A_ST, v); check("R3 toggle alone clears", v, 32'h0);
  endtask

  task automatic t_level();
    logic [31:0] v;
    step(1'b0, A_ST, 32'h0, 4'b0100);
    rd(A_ST, v); check("R2 level sets once", v, 32'h4);
    step(1'b1, A_ST, 32'h4, 4'b0100);
    step(1'b0, A_ST, 32'h0, 4'b0100);
    step(1'b0, A_ST, 32'h0, 4'b0100);
    rd(A_ST, v); check("R2 held level no reset", v, 32'h0);
    step(1'b0, A_ST, 32'h0, 4'b0000);
  endtask

  task automatic t_other();
    logic [31:0] v;
    step(1'b1, A_GAP, 32'hFFFF_FFFF, 4'b0000);
    rd(A_GAP, v); check("R9 gap reads zero", v, 32'h0);
    rd(A_ST, v);  check("R9 status untouched", v, 32'h0);
    rd(A_EN, v);  check("R9 enable untouched", v, 32'h4);
    rd(A_GLB, v); check("R9 global untouched", v, 32'h8000_0000);
  endtask

  task automatic t_first_cycle();
    logic [31:0] v;
    ev = 4'b0001; rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rd(A_ST, v); check("R1 status held in reset", v, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    rd(A_ST, v); check("R2 high at release", v, 32'h1);
    ev = 4'b0000;
  endtask

  initial begin
    rst = 1'b1; ev = '0; addr = '0; wr = 1'b0; wdata = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_capture();
    t_toggle();
    t_enable();
    t_global();
    t_race();
    t_level();
    t_other();
    t_first_cycle();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule